// File: doc/BRIEF.md
# Pairable Nibble GPIO Port Controller

This block controls two neighbouring 4-bit bidirectional I/O ports through a small register bus. Each pin has four control bits: an output latch, a direction bit, a pull-up request and a drive-mode bit. The drive-mode bit selects push-pull or n-channel open-drain drive. The block turns these bits into pad-control signals: output value, output enable and pull-up enable. It takes raw pad inputs and passes them through a two-flop synchronizer, so input pins can be read safely.

A bus request works on a whole nibble, a single bit, or both ports joined into one 8-bit word. In the joined case, port 0 carries the low nibble. A separate bit-test operation copies one selected bit onto a flag and changes no register. Reads return the pad level for input pins and the latch for output pins. Read data and the test flag are registered, so they are valid one clock after the request.

Top module: `gpio_pair_ctrl`

## Requirements
- R1: While reset is applied and after it is released, every latch is 0, every pin is an input, every pull-up is off and every bit is push-pull. As a result, `pad_out_o`, `pad_oe_o`, `pad_pu_o`, `rdata_o` and `test_o` are all 0.
- R2: Register `reg_i`=1 holds the direction bits (1 = output). A push-pull output pin has `pad_oe_o`=1. An input pin has `pad_oe_o`=0.
- R3: A read (`req_i`=1, `we_i`=0, `op_i`≠3) of the data register (`reg_i`=0) returns the latch bit for output pins and the synchronized pad level for input pins. A pad change becomes readable after two clock edges. The read value appears on `rdata_o` after the next rising edge and is held until the next read.
- R4: Register `reg_i`=2 holds the pull-up requests. `pad_pu_o` is the request ANDed with "pin is input", so an output pin never has its pull-up on.
- R5: Register `reg_i`=3 holds the drive mode (1 = open-drain). On an open-drain output pin, `pad_oe_o` is 1 only while the latch bit is 0; while the latch bit is 1 the pad floats.
- R6: `op_i`=2 is the paired 8-bit access. A paired write loads `wdata_i[3:0]` into port 0 and `wdata_i[7:4]` into port 1 of the selected register in one cycle. A paired read returns port 1 in bits [7:4] and port 0 in bits [3:0].
- R7: `op_i`=3 is bit-test. It loads the bit of the selected register selected by `port_i` and `bit_i` onto `test_o` (for the data register, the pin value as in R3). It changes no register and no output other than `test_o`, whatever the value of `we_i`.
- R8: `op_i`=0 is a nibble access to port `port_i`. A write loads `wdata_i[3:0]`. A read returns the nibble zero-extended on `rdata_o`.
- R9: `op_i`=1 is a single-bit access to pin `bit_i` of port `port_i`. A write sets that bit to `wdata_i[0]` and leaves the other seven bits of the register unchanged. A read returns the bit in `rdata_o[0]` with bits [7:1] set to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus request strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| op_i | input | 2 | Access kind: 0 nibble, 1 bit, 2 paired byte, 3 bit-test |
| reg_i | input | 2 | Register: 0 data, 1 direction, 2 pull-up, 3 drive mode |
| port_i | input | 1 | Port select for nibble, bit and test accesses |
| bit_i | input | 2 | Pin select inside the port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| test_o | output | 1 | Registered bit-test flag |
| pad_in_i | input | 8 | Raw pad levels, port 1 in [7:4] |
| pad_out_o | output | 8 | Pad output values (output latches) |
| pad_oe_o | output | 8 | Pad output enables |
| pad_pu_o | output | 8 | Pad pull-up enables |

## Verification
Pad outputs show any damage to a latch, direction, pull-up or drive-mode bit on the clock edge after the faulty write. This covers a bit write that spills into a neighbour, a paired write that swaps nibbles, and a test access that writes. The bench compares all three pad vectors after every access, so such a fault shows within one access. Damage in the read mux or the synchronizer shows only on `rdata_o` or `test_o`, one edge after a read or test. For this reason the random stream mixes every register, access kind and pad pattern.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;
  typedef enum logic [1:0] {
    OP_NIB  = 2'd0,
    OP_BIT  = 2'd1,
    OP_PAIR = 2'd2,
    OP_TEST = 2'd3
  } acc_op_e;

  typedef enum logic [1:0] {
    RG_DATA = 2'd0,
    RG_DIR  = 2'd1,
    RG_PULL = 2'd2,
    RG_MODE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else if (s == 0) stg_q[s] <= d_i;
        else stg_q[s] <= stg_q[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_nibble_port.sv
module gpio_nibble_port
  import gpio_pair_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_reg_i,
  input  logic [NIB_W-1:0] wr_mask_i,
  input  logic [NIB_W-1:0] wr_val_i,
  input  logic [NIB_W-1:0] pin_sync_i,
  output logic [NIB_W-1:0] pin_val_o,
  output logic [NIB_W-1:0] dir_o,
  output logic [NIB_W-1:0] pull_o,
  output logic [NIB_W-1:0] mode_o,
  output logic [NIB_W-1:0] pad_out_o,
  output logic [NIB_W-1:0] pad_oe_o,
  output logic [NIB_W-1:0] pad_pu_o
);
  logic [NIB_W-1:0] lat_q, dir_q, pull_q, mode_q;

  function automatic logic [NIB_W-1:0] merge(input logic [NIB_W-1:0] old,
                                             input logic [NIB_W-1:0] msk,
                                             input logic [NIB_W-1:0] val);
    return (old & ~msk) | (val & msk);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      dir_q  <= '0;
      pull_q <= '0;
      mode_q <= '0;
    end else if (wr_en_i) begin
      unique case (reg_sel_e'(wr_reg_i))
        RG_DATA: lat_q  <= merge(lat_q,  wr_mask_i, wr_val_i);
        RG_DIR:  dir_q  <= merge(dir_q,  wr_mask_i, wr_val_i);
        RG_PULL: pull_q <= merge(pull_q, wr_mask_i, wr_val_i);
        RG_MODE: mode_q <= merge(mode_q, wr_mask_i, wr_val_i);
        default: ;
      endcase
    end
  end

  generate
    for (genvar b = 0; b < NIB_W; b++) begin : g_pin
      // open-drain: drive only the low level
      assign pad_oe_o[b]  = dir_q[b] & ~(mode_q[b] & lat_q[b]);
      assign pad_pu_o[b]  = pull_q[b] & ~dir_q[b];
      assign pin_val_o[b] = dir_q[b] ? lat_q[b] : pin_sync_i[b];
    end
  endgenerate

  assign pad_out_o = lat_q;
  assign dir_o     = dir_q;
  assign pull_o    = pull_q;
  assign mode_o    = mode_q;
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_pair_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int BUS_W = 2 * NIB_W,
  localparam int BIT_W = $clog2(NIB_W)
) (
  input  logic [1:0]       op_i,
  input  logic [1:0]       reg_i,
  input  logic             port_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic [BUS_W-1:0] pin_val_i,
  input  logic [BUS_W-1:0] dir_i,
  input  logic [BUS_W-1:0] pull_i,
  input  logic [BUS_W-1:0] mode_i,
  output logic [BUS_W-1:0] rd_val_o,
  output logic             tst_bit_o
);
  logic [BUS_W-1:0] src;
  logic [NIB_W-1:0] nib;
  logic             sel_bit;

  always_comb begin
    unique case (reg_sel_e'(reg_i))
      RG_DATA: src = pin_val_i;
      RG_DIR:  src = dir_i;
      RG_PULL: src = pull_i;
      default: src = mode_i;
    endcase
    nib     = port_i ? src[BUS_W-1:NIB_W] : src[NIB_W-1:0];
    sel_bit = nib[bit_i];
    unique case (acc_op_e'(op_i))
      OP_PAIR: rd_val_o = src;
      OP_NIB:  rd_val_o = {{NIB_W{1'b0}}, nib};
      default: rd_val_o = {{(BUS_W-1){1'b0}}, sel_bit};
    endcase
  end

  assign tst_bit_o = sel_bit;
endmodule

// File: rtl/gpio_pair_ctrl.sv
module gpio_pair_ctrl
  import gpio_pair_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_PORTS  = 2,
  localparam int BUS_W      = NUM_PORTS * NIB_W,
  localparam int BIT_W      = $clog2(NIB_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       op_i,
  input  logic [1:0]       reg_i,
  input  logic             port_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             test_o,
  input  logic [BUS_W-1:0] pad_in_i,
  output logic [BUS_W-1:0] pad_out_o,
  output logic [BUS_W-1:0] pad_oe_o,
  output logic [BUS_W-1:0] pad_pu_o
);
  logic [BUS_W-1:0] pad_sync, pin_val_all, dir_all, pull_all, mode_all;
  logic [BUS_W-1:0] rd_val;
  logic             tst_bit;
  logic             wr_act, rd_act, tst_act;
  logic [NIB_W-1:0] bit_oh;
  logic [BUS_W-1:0] rdata_q;
  logic             test_q;

  assign tst_act = req_i & (acc_op_e'(op_i) == OP_TEST);
  assign wr_act  = req_i & we_i & ~tst_act;
  assign rd_act  = req_i & ~we_i & ~tst_act;
  assign bit_oh  = {{(NIB_W-1){1'b0}}, 1'b1} << bit_i;

  gpio_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pad_sync)
  );

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic             wr_en;
      logic [NIB_W-1:0] wr_mask, wr_val;

      always_comb begin
        wr_en   = 1'b0;
        wr_mask = '0;
        wr_val  = '0;
        unique case (acc_op_e'(op_i))
          OP_PAIR: begin
            wr_en   = wr_act;
            wr_mask = '1;
            wr_val  = wdata_i[p*NIB_W +: NIB_W];
          end
          OP_NIB: begin
            wr_en   = wr_act & (port_i == p[0]);
            wr_mask = '1;
            wr_val  = wdata_i[NIB_W-1:0];
          end
          OP_BIT: begin
            wr_en   = wr_act & (port_i == p[0]);
            wr_mask = bit_oh;
            wr_val  = {NIB_W{wdata_i[0]}};
          end
          default: ;
        endcase
      end

      gpio_nibble_port #(.NIB_W(NIB_W)) u_port (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en),
        .wr_reg_i  (reg_i),
        .wr_mask_i (wr_mask),
        .wr_val_i  (wr_val),
        .pin_sync_i(pad_sync[p*NIB_W +: NIB_W]),
        .pin_val_o (pin_val_all[p*NIB_W +: NIB_W]),
        .dir_o     (dir_all[p*NIB_W +: NIB_W]),
        .pull_o    (pull_all[p*NIB_W +: NIB_W]),
        .mode_o    (mode_all[p*NIB_W +: NIB_W]),
        .pad_out_o (pad_out_o[p*NIB_W +: NIB_W]),
        .pad_oe_o  (pad_oe_o[p*NIB_W +: NIB_W]),
        .pad_pu_o  (pad_pu_o[p*NIB_W +: NIB_W])
      );
    end
  endgenerate

  gpio_read_mux #(.NIB_W(NIB_W)) u_rmux (
    .op_i     (op_i),
    .reg_i    (reg_i),
    .port_i   (port_i),
    .bit_i    (bit_i),
    .pin_val_i(pin_val_all),
    .dir_i    (dir_all),
    .pull_i   (pull_all),
    .mode_i   (mode_all),
    .rd_val_o (rd_val),
    .tst_bit_o(tst_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      test_q  <= 1'b0;
    end else begin
      if (rd_act)  rdata_q <= rd_val;
      if (tst_act) test_q  <= tst_bit;
    end
  end

  assign rdata_o = rdata_q;
  assign test_o  = test_q;
endmodule

// File: rtl/gpio_pair_chk.sv
module gpio_pair_chk
  import gpio_pair_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int BUS_W = 2 * NIB_W,
  localparam int BIT_W = $clog2(NIB_W)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [1:0]       op_i,
  input logic [1:0]       reg_i,
  input logic             port_i,
  input logic [BIT_W-1:0] bit_i,
  input logic [BUS_W-1:0] wdata_i,
  input logic [BUS_W-1:0] rdata_o,
  input logic             test_o,
  input logic [BUS_W-1:0] pad_out_o,
  input logic [BUS_W-1:0] pad_oe_o,
  input logic [BUS_W-1:0] pad_pu_o,
  input logic [BUS_W-1:0] dir_all,
  input logic [BUS_W-1:0] mode_all
);
  logic [BUS_W-1:0] tgt_mask;
  logic             data_wr, is_test;

  assign tgt_mask = {{(BUS_W-1){1'b0}}, 1'b1} << {port_i, bit_i};
  assign data_wr  = req_i & we_i & (reg_sel_e'(reg_i) == RG_DATA);
  assign is_test  = req_i & (acc_op_e'(op_i) == OP_TEST);

  p_reset_idle_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (pad_out_o == '0 && pad_oe_o == '0 && pad_pu_o == '0 &&
                       rdata_o == '0 && !test_o));

  p_push_pull_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dir_all & ~mode_all & ~pad_oe_o) == '0));

  p_pull_off_out_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_pu_o & dir_all) == '0));

  p_od_no_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & mode_all & pad_out_o) == '0));

  p_pair_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && acc_op_e'(op_i) == OP_PAIR) |=> (pad_out_o == $past(wdata_i)));

  p_test_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_test |=> ($stable(pad_out_o) && $stable(pad_oe_o) && $stable(pad_pu_o) &&
                 $stable(rdata_o)));

  p_bit_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && acc_op_e'(op_i) == OP_BIT) |=>
      (((pad_out_o ^ $past(pad_out_o)) & ~$past(tgt_mask)) == '0));
endmodule

bind gpio_pair_ctrl gpio_pair_chk #(.NIB_W(NIB_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .op_i     (op_i),
  .reg_i    (reg_i),
  .port_i   (port_i),
  .bit_i    (bit_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .test_o   (test_o),
  .pad_out_o(pad_out_o),
  .pad_oe_o (pad_oe_o),
  .pad_pu_o (pad_pu_o),
  .dir_all  (dir_all),
  .mode_all (mode_all)
);

// File: tb/tb_gpio_pair_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_pair_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, we_i = 1'b0, port_i = 1'b0, test_o;
  logic [1:0] op_i = '0, reg_i = '0, bit_i = '0;
  logic [7:0] wdata_i = '0, rdata_o, pad_in_i = '0, pad_out_o, pad_oe_o, pad_pu_o;

  int total = 0, bad = 0;
  logic [7:0] m_lat = '0, m_dir = '0, m_pu = '0, m_od = '0, m_rd = '0;
  logic       m_tst = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gpio_pair_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .op_i(op_i),
    .reg_i(reg_i), .port_i(port_i), .bit_i(bit_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .test_o(test_o), .pad_in_i(pad_in_i),
    .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o), .pad_pu_o(pad_pu_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] src_of(input logic [1:0] r);
    case (r)
      2'd0: return (m_dir & m_lat) | (~m_dir & pad_in_i);
      2'd1: return m_dir;
      2'd2: return m_pu;
      default: return m_od;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] op, input logic [1:0] r,
                                          input logic p, input logic [1:0] b);
    logic [7:0] s = src_of(r);
    logic [3:0] n = p ? s[7:4] : s[3:0];
    case (op)
      2'd2: return s;
      2'd0: return {4'h0, n};
      default: return {7'h0, n[b]};
    endcase
  endfunction

  function automatic logic [7:0] upd(input logic [7:0] old, input logic [1:0] op,
                                     input logic p, input logic [1:0] b, input logic [7:0] wd);
    logic [7:0] msk, val;
    case (op)
      2'd2: begin msk = 8'hFF; val = wd; end
      2'd0: begin msk = p ? 8'hF0 : 8'h0F; val = {wd[3:0], wd[3:0]}; end
      default: begin msk = 8'h01 << {p, b}; val = {8{wd[0]}}; end
    endcase
    return (old & ~msk) | (val & msk);
  endfunction

  task automatic check_pads(input string tag);
    chk({tag, " pad_out"}, pad_out_o, m_lat);
    chk({"R2/R5 ", tag, " pad_oe"}, pad_oe_o, m_dir & ~(m_od & m_lat));
    chk({"R4 ", tag, " pad_pu"}, pad_pu_o, m_pu & ~m_dir);
    chk({"R3 ", tag, " rdata"}, rdata_o, m_rd);
    chk({"R7 ", tag, " test"}, {7'h0, test_o}, {7'h0, m_tst});
  endtask

  task automatic acc(input string tag, input logic [1:0] op, input logic we,
                     input logic [1:0] r, input logic p, input logic [1:0] b,
                     input logic [7:0] wd);
    logic [7:0] ev;
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; op_i = op; reg_i = r; port_i = p; bit_i = b; wdata_i = wd;
    ev = exp_read(op, r, p, b);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    if (op == 2'd3) m_tst = ev[0];
    else if (!we) m_rd = ev;
    else begin
      case (r)
        2'd0: m_lat = upd(m_lat, op, p, b, wd);
        2'd1: m_dir = upd(m_dir, op, p, b, wd);
        2'd2: m_pu  = upd(m_pu,  op, p, b, wd);
        default: m_od = upd(m_od, op, p, b, wd);
      endcase
    end
    check_pads(tag);
  endtask

  task automatic set_pad(input logic [7:0] v);
    @(negedge clk_i);
    pad_in_i = v;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C1A));
    repeat (3) @(negedge clk_i);
    check_pads("R1 reset-held");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_pads("R1 after-release");

    // R3: input pins read pad levels after synchronization
    set_pad(8'h96);
    acc("R3 pair read inputs", 2'd2, 1'b0, 2'd0, 1'b0, 2'd0, 8'h00);
    chk("R3 pair read pad", rdata_o, 8'h96);
    // R6: paired write, port 0 low nibble
    acc("R6 pair write latch", 2'd2, 1'b1, 2'd0, 1'b0, 2'd0, 8'hA5);
    chk("R6 latch low/high", pad_out_o, 8'hA5);
    // R2: all outputs push-pull
    acc("R2 dir all out", 2'd2, 1'b1, 2'd1, 1'b0, 2'd0, 8'hFF);
    chk("R2 oe all", pad_oe_o, 8'hFF);
    acc("R3 read output latch", 2'd2, 1'b0, 2'd0, 1'b0, 2'd0, 8'h00);
    chk("R3 output pins return latch", rdata_o, 8'hA5);
    // R5: open-drain on port 1
    acc("R5 od nibble", 2'd0, 1'b1, 2'd3, 1'b1, 2'd0, 8'h0F);
    chk("R5 od floats on 1", pad_oe_o, 8'h5F);
    // R4: pull-ups requested but pins are outputs
    acc("R4 pu all", 2'd2, 1'b1, 2'd2, 1'b0, 2'd0, 8'hFF);
    chk("R4 pu off for outputs", pad_pu_o, 8'h00);
    acc("R4 port0 to input", 2'd0, 1'b1, 2'd1, 1'b0, 2'd0, 8'h00);
    chk("R4 pu on for inputs", pad_pu_o, 8'h0F);
    // R9: single bit write
    acc("R9 bit write", 2'd1, 1'b1, 2'd0, 1'b1, 2'd2, 8'hFE);
    chk("R9 only bit 6 cleared", pad_out_o, 8'hA5 & ~8'h40);
    // R8: nibble read zero-extended
    acc("R8 nibble read dir", 2'd0, 1'b0, 2'd1, 1'b1, 2'd0, 8'h00);
    chk("R8 zero-extended", rdata_o, 8'h0F);
    // R7: test with we=1 writes nothing
    acc("R7 test we=1", 2'd3, 1'b1, 2'd0, 1'b1, 2'd0, 8'h00);
    chk("R7 latch unchanged", pad_out_o, 8'hA5 & ~8'h40);

    for (int i = 0; i < 600; i++) begin
      logic [1:0] op = 2'($urandom_range(0, 3));
      logic we = 1'($urandom_range(0, 1));
      logic [1:0] r = 2'($urandom_range(0, 3));
      logic p = 1'($urandom_range(0, 1));
      logic [1:0] b = 2'($urandom_range(0, 3));
      logic [7:0] wd = 8'($urandom);
      if ($urandom_range(0, 15) == 0) set_pad(8'($urandom));
      case (op)
        2'd0: acc("R8 rand nibble", op, we, r, p, b, wd);
        2'd1: acc("R9 rand bit", op, we, r, p, b, wd);
        2'd2: acc("R6 rand pair", op, we, r, p, b, wd);
        default: acc("R7 rand test", op, we, r, p, b, wd);
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule